// File: doc/BRIEF.md
# Converter Power-Mode Controller

This block selects the power state of a data converter's digital side and drives three enables: one for the conversion core, one for the internal references and one for the output drivers. It also drives a high-impedance control for the data outputs and a data-valid flag. The commanded state is a two-bit code. A source-select input picks whether that code comes from two dedicated mode pins or from two control-register bits. The code is registered once in the reference timebase domain before it takes effect.

Each return to normal operation starts a wake-up down-counter that runs on the reference timebase. The count loaded depends on the state being left. A slow state (standby, full power-down or lost sample clock) loads a long count. Leaving the output-driver-off state loads a short count, and that count is shorter again when the outputs use single-ended CMOS levels rather than differential signalling. Data-valid rises only when the counter reaches zero.

A clock monitor counts sample-clock edges over fixed windows of the reference timebase. When two windows in a row fall below a threshold while normal operation is commanded, the block falls back on its own to a lost-clock state. It returns to normal through the long wake-up once two windows in a row are above the threshold again.

Top module: `cvt_power_ctrl`

## Requirements
- R1: The two-bit command {first, second} maps to states as follows: 00 is normal, 01 is standby, 10 is output-driver-off and 11 is full power-down. With `src_is_reg`=0 the first bit is `pin_sel1` and the second is `pin_sel0`. With `src_is_reg`=1 the first bit is `reg_buf_pd` and the second is `reg_core_sb`.
- R2: While one source is selected, the bits of the other source have no effect on any output.
- R3: In standby, `core_en`=0, `ref_en`=1, `obuf_en`=1, `out_hiz`=0 and `data_valid`=0.
- R4: In full power-down, all three enables are 0, `out_hiz`=1 and `data_valid`=0.
- R5: In output-driver-off, `core_en`=1, `ref_en`=1, `obuf_en`=0, `out_hiz`=1 and `data_valid`=0.
- R6: In normal operation, all three enables are 1 and `out_hiz`=0. Data-valid rises exactly DLY_SLOW reference cycles after the block enters normal from standby, full power-down or lost-clock.
- R7: On entry to normal from output-driver-off, data-valid rises exactly DLY_DIFF cycles later when `fmt_cmos`=0, and exactly DLY_CMOS cycles later when `fmt_cmos`=1.
- R8: A window of WIN reference cycles that sees fewer than THRESH sample-clock rising edges is a slow measurement. Two consecutive slow measurements while normal is commanded enter the lost-clock state (`core_en`=0, `ref_en`=1, `obuf_en`=1, `out_hiz`=0, `data_valid`=0). Two consecutive fast measurements leave that state.
- R9: A change of command while a wake-up count is running restarts the sequence. Data-valid stays low, and the next entry to normal loads the count for the state most recently left.
- R10: While reset is asserted, and until the first normal command has finished its wake-up, the block is in full power-down or waking from it, with `data_valid`=0.
- R11: A change of the selected command reaches the enables on the second rising reference edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_clk | input | 1 | Converter sample clock (monitored) |
| pin_sel1 | input | 1 | Mode pin, first command bit |
| pin_sel0 | input | 1 | Mode pin, second command bit |
| reg_buf_pd | input | 1 | Register bit, first command bit |
| reg_core_sb | input | 1 | Register bit, second command bit |
| src_is_reg | input | 1 | 1 selects register bits, 0 selects pins |
| fmt_cmos | input | 1 | 1 for single-ended CMOS outputs, 0 for differential |
| core_en | output | 1 | Conversion core enable |
| ref_en | output | 1 | Internal reference enable |
| obuf_en | output | 1 | Output driver enable |
| out_hiz | output | 1 | Data outputs high-impedance |
| data_valid | output | 1 | Output data valid |

## Verification
The assertions assume that the sample clock toggles well below half the reference rate, so that the synchronised toggle never drops an edge. They also assume that `fmt_cmos` is steady whenever a wake-up count is loaded. The stimulus runs the sample clock at a period of four or forty reference cycles, or stops it. It changes regime only halfway through a measurement window, so a few cycles of synchroniser delay cannot move a measurement across the threshold. The output format changes only while the command holds a non-normal state.

// File: rtl/cvt_pwr_pkg.sv
package cvt_pwr_pkg;

   typedef enum logic [2:0] {
      PS_NORMAL   = 3'd0,
      PS_STANDBY  = 3'd1,
      PS_BUF_OFF  = 3'd2,
      PS_ALL_OFF  = 3'd3,
      PS_CLK_LOST = 3'd4
   } pwr_state_e;

   typedef struct packed {
      logic core;
      logic refs;
      logic obuf;
   } pwr_en_t;

   function automatic pwr_en_t enables_of(pwr_state_e s);
      pwr_en_t e;
      case (s)
         PS_NORMAL:   e = '{core: 1'b1, refs: 1'b1, obuf: 1'b1};
         PS_STANDBY:  e = '{core: 1'b0, refs: 1'b1, obuf: 1'b1};
         PS_BUF_OFF:  e = '{core: 1'b1, refs: 1'b1, obuf: 1'b0};
         PS_CLK_LOST: e = '{core: 1'b0, refs: 1'b1, obuf: 1'b1};
         default:     e = '{core: 1'b0, refs: 1'b0, obuf: 1'b0};
      endcase
      return e;
   endfunction

endpackage

// File: rtl/cvt_mode_src.sv
module cvt_mode_src
   import cvt_pwr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] pin_code,
   input  logic [1:0] reg_code,
   input  logic       src_is_reg,
   output pwr_state_e cmd_q
);

   logic [1:0] code_sel;

   assign code_sel = src_is_reg ? reg_code : pin_code;

   // code value equals the enum encoding of the four commanded states
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd_q <= PS_ALL_OFF;
      else        cmd_q <= pwr_state_e'({1'b0, code_sel});
   end

endmodule

// File: rtl/cvt_clk_monitor.sv
module cvt_clk_monitor #(
   parameter int unsigned WIN         = 64,
   parameter int unsigned THRESH      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          TWO_WINDOW  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_clk,
   output logic clk_slow
);

   localparam int unsigned WW = (WIN > 1) ? $clog2(WIN) : 1;
   localparam int unsigned EW = $clog2(WIN + 1);

   logic                 smp_tog;
   logic [SYNC_STAGES:0] sync_q;
   logic                 edge_seen;
   logic [WW-1:0]        win_q;
   logic [EW-1:0]        edge_q;
   logic [EW-1:0]        edge_total;
   logic                 win_end;
   logic                 meas_slow;

   always_ff @(posedge smp_clk or negedge rst_n) begin
      if (!rst_n) smp_tog <= 1'b0;
      else        smp_tog <= ~smp_tog;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-1:0], smp_tog};
   end

   assign edge_seen  = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];
   assign edge_total = edge_q + EW'(edge_seen);
   assign win_end    = (win_q == WW'(WIN - 1));
   assign meas_slow  = (edge_total < EW'(THRESH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         edge_q <= '0;
      end else if (win_end) begin
         win_q  <= '0;
         edge_q <= '0;
      end else begin
         win_q  <= win_q + WW'(1);
         edge_q <= edge_total;
      end
   end

   generate
      if (TWO_WINDOW) begin : g_filtered
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q   <= 1'b0;
               clk_slow <= 1'b0;
            end else if (win_end) begin
               prev_q <= meas_slow;
               if (meas_slow == prev_q) clk_slow <= meas_slow;
            end
         end
      end else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       clk_slow <= 1'b0;
            else if (win_end) clk_slow <= meas_slow;
         end
      end
   endgenerate

endmodule

// File: rtl/cvt_wake_seq.sv
module cvt_wake_seq
   import cvt_pwr_pkg::*;
#(
   parameter int unsigned DLY_SLOW = 200,
   parameter int unsigned DLY_DIFF = 20,
   parameter int unsigned DLY_CMOS = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  pwr_state_e cmd,
   input  logic       clk_slow,
   input  logic       fmt_cmos,
   output pwr_state_e cur_q,
   output logic       valid_q
);

   localparam int unsigned CW = $clog2(DLY_SLOW + 1);

   pwr_state_e    target;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] load_val;

   assign target = (clk_slow && cmd == PS_NORMAL) ? PS_CLK_LOST : cmd;

   always_comb begin
      if (cur_q == PS_BUF_OFF) load_val = fmt_cmos ? CW'(DLY_CMOS) : CW'(DLY_DIFF);
      else                     load_val = CW'(DLY_SLOW);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q   <= PS_ALL_OFF;
         cnt_q   <= '0;
         valid_q <= 1'b0;
      end else if (target != cur_q) begin
         cur_q   <= target;
         valid_q <= 1'b0;
         cnt_q   <= (target == PS_NORMAL) ? load_val : '0;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CW'(1);
         if (cnt_q == CW'(1)) valid_q <= 1'b1;
      end
   end

endmodule

// File: rtl/cvt_power_ctrl.sv
module cvt_power_ctrl
   import cvt_pwr_pkg::*;
#(
   parameter int unsigned DLY_SLOW    = 200,
   parameter int unsigned DLY_DIFF    = 20,
   parameter int unsigned DLY_CMOS    = 8,
   parameter int unsigned WIN         = 64,
   parameter int unsigned THRESH      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          TWO_WINDOW  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_clk,
   input  logic pin_sel1,
   input  logic pin_sel0,
   input  logic reg_buf_pd,
   input  logic reg_core_sb,
   input  logic src_is_reg,
   input  logic fmt_cmos,
   output logic core_en,
   output logic ref_en,
   output logic obuf_en,
   output logic out_hiz,
   output logic data_valid
);

   generate
      if (DLY_CMOS < 1 || DLY_CMOS > DLY_DIFF || DLY_DIFF > DLY_SLOW) begin : g_bad_dly
         $error("wake delays must satisfy 1 <= DLY_CMOS <= DLY_DIFF <= DLY_SLOW");
      end
      if (THRESH < 1 || THRESH >= WIN) begin : g_bad_win
         $error("THRESH must lie in 1..WIN-1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   pwr_state_e cmd_q;
   pwr_state_e cur_st;
   logic       clk_slow;
   pwr_en_t    en;

   cvt_mode_src u_src (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_code   ({pin_sel1, pin_sel0}),
      .reg_code   ({reg_buf_pd, reg_core_sb}),
      .src_is_reg (src_is_reg),
      .cmd_q      (cmd_q)
   );

   cvt_clk_monitor #(
      .WIN         (WIN),
      .THRESH      (THRESH),
      .SYNC_STAGES (SYNC_STAGES),
      .TWO_WINDOW  (TWO_WINDOW)
   ) u_mon (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_clk  (smp_clk),
      .clk_slow (clk_slow)
   );

   cvt_wake_seq #(
      .DLY_SLOW (DLY_SLOW),
      .DLY_DIFF (DLY_DIFF),
      .DLY_CMOS (DLY_CMOS)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd_q),
      .clk_slow (clk_slow),
      .fmt_cmos (fmt_cmos),
      .cur_q    (cur_st),
      .valid_q  (data_valid)
   );

   assign en      = enables_of(cur_st);
   assign core_en = en.core;
   assign ref_en  = en.refs;
   assign obuf_en = en.obuf;
   assign out_hiz = ~en.obuf;

endmodule

// File: rtl/cvt_power_ctrl_chk.sv
module cvt_power_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic core_en,
   input logic ref_en,
   input logic obuf_en,
   input logic out_hiz,
   input logic data_valid
);

   // R6: valid data only with every block powered and outputs driven
   assert_valid_full_power_R6: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> (core_en && ref_en && obuf_en && !out_hiz));

   // R4: references are dropped only in full power-down
   assert_refs_off_all_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_en |-> (!core_en && !obuf_en && out_hiz));

   // R5: high-impedance outputs never carry valid data
   assert_hiz_not_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_hiz |-> !data_valid);

   // R9: a wake-up always takes at least one cycle after the core is back
   assert_no_instant_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !core_en |=> !data_valid);

   // R6: data-valid rises only after a cycle at full power
   assert_rise_after_awake_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_valid) |-> ($past(core_en) && $past(obuf_en)));

endmodule

bind cvt_power_ctrl cvt_power_ctrl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .core_en    (core_en),
   .ref_en     (ref_en),
   .obuf_en    (obuf_en),
   .out_hiz    (out_hiz),
   .data_valid (data_valid)
);

// File: tb/cvt_power_ctrl_test.sv
`timescale 1ns/1ps
module cvt_power_ctrl_test;

   localparam int DS  = 200;
   localparam int DD  = 20;
   localparam int DC  = 8;
   localparam int WIN = 64;
   localparam int THR = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_clk = 1'b0;
   logic pin_sel1 = 1'b1, pin_sel0 = 1'b1;
   logic reg_buf_pd = 1'b0, reg_core_sb = 1'b0;
   logic src_is_reg = 1'b0, fmt_cmos = 1'b0;
   logic core_en, ref_en, obuf_en, out_hiz, data_valid;

   int total = 0, bad = 0, cyc = 0;
   string cur_req = "R10";
   bit cmp_on = 1'b0;

   cvt_power_ctrl #(.DLY_SLOW(DS), .DLY_DIFF(DD), .DLY_CMOS(DC), .WIN(WIN), .THRESH(THR)) uut (
      .clk(clk), .rst_n(rst_n), .smp_clk(smp_clk),
      .pin_sel1(pin_sel1), .pin_sel0(pin_sel0),
      .reg_buf_pd(reg_buf_pd), .reg_core_sb(reg_core_sb),
      .src_is_reg(src_is_reg), .fmt_cmos(fmt_cmos),
      .core_en(core_en), .ref_en(ref_en), .obuf_en(obuf_en),
      .out_hiz(out_hiz), .data_valid(data_valid));

   always #2 clk = ~clk;

   // sample clock: toggles every smp_half reference cycles, stopped at 0
   int smp_half = 2, hc = 0, rises = 0;
   always @(negedge clk) begin
      if (smp_half == 0) begin smp_clk <= 1'b0; hc <= 0; end
      else if (hc + 1 >= smp_half) begin smp_clk <= ~smp_clk; hc <= 0; end
      else hc <= hc + 1;
   end
   always @(posedge smp_clk) rises++;

   // behavioural reference model (0 normal,1 standby,2 buffers off,3 all off,4 clock lost)
   int m_cmd = 3, m_cur = 3, m_cnt = 0, m_win = 0, m_base = 0;
   bit m_val = 0, m_slow = 0, m_prev = 0;
   always @(posedge clk) begin
      int eff;
      bit meas;
      cyc++;
      if (!rst_n) begin
         m_cmd = 3; m_cur = 3; m_cnt = 0; m_val = 0;
         m_slow = 0; m_prev = 0; m_win = 0; m_base = rises;
      end else begin
         eff = (m_slow && m_cmd == 0) ? 4 : m_cmd;
         if (eff != m_cur) begin
            if (eff == 0) m_cnt = (m_cur == 2) ? (fmt_cmos ? DC : DD) : DS;
            else m_cnt = 0;
            m_cur = eff; m_val = 0;
         end else if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) m_val = 1;
         end
         if (m_win == WIN - 1) begin
            meas = (rises - m_base) < THR;
            if (meas == m_prev) m_slow = meas;
            m_prev = meas; m_base = rises; m_win = 0;
         end else m_win++;
         m_cmd = src_is_reg ? {reg_buf_pd, reg_core_sb} : {pin_sel1, pin_sel0};
      end
   end

   function automatic logic [4:0] model_out(int s, bit v);
      case (s)
         0: return {4'b1110, v};
         1: return 5'b01100;
         2: return 5'b11010;
         4: return 5'b01100;
         default: return 5'b00010;
      endcase
   endfunction

   function automatic logic [4:0] dut_out();
      return {core_en, ref_en, obuf_en, out_hiz, data_valid};
   endfunction

   task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%b expected=%b (core,ref,obuf,hiz,valid) at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) if (cmp_on) chk(cur_req, dut_out(), model_out(m_cur, m_val));

   // watchdog
   always @(posedge clk) if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pins(logic [1:0] c);
      {pin_sel1, pin_sel0} = c;
   endtask

   // counts rising edges until data_valid is seen high
   task automatic wake(string req, int exp_edges);
      int n = 0;
      do begin @(negedge clk); n++; end while (!data_valid && n < 2000);
      total++;
      if (n != exp_edges) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d wake edges", req, n, exp_edges);
      end
   endtask

   task automatic mid_window();
      do @(negedge clk); while (m_win != WIN / 2);
   endtask

   initial begin
      // R10: reset state
      ticks(3);
      chk("R10", dut_out(), 5'b00010);
      cmp_on = 1'b1;
      rst_n = 1'b1;
      ticks(10);
      chk("R10", dut_out(), 5'b00010);

      // R10 / R6: first normal command after reset
      cur_req = "R6";
      pins(2'b00);
      wake("R10", 2 + DS);
      chk("R6", dut_out(), 5'b11101);

      // R3 / R11: standby, latency of two edges
      cur_req = "R3";
      pins(2'b01);
      ticks(1);
      chk("R11", dut_out(), 5'b11101);
      ticks(1);
      chk("R3", dut_out(), 5'b01100);
      ticks(5);
      pins(2'b00);
      wake("R6", 2 + DS);

      // R5 / R7 differential
      cur_req = "R5";
      pins(2'b10);
      ticks(3);
      chk("R5", dut_out(), 5'b11010);
      cur_req = "R7";
      pins(2'b00);
      wake("R7", 2 + DD);

      // R7 CMOS
      pins(2'b10);
      ticks(3);
      fmt_cmos = 1'b1;
      ticks(2);
      pins(2'b00);
      wake("R7", 2 + DC);
      fmt_cmos = 1'b0;

      // R4: full power-down by pins then wake
      cur_req = "R4";
      pins(2'b11);
      ticks(3);
      chk("R4", dut_out(), 5'b00010);
      pins(2'b00);
      wake("R6", 2 + DS);

      // R1 / R2: register source
      cur_req = "R1";
      reg_buf_pd = 1'b1; reg_core_sb = 1'b1;
      src_is_reg = 1'b1;
      ticks(3);
      chk("R1", dut_out(), 5'b00010);
      pins(2'b01);
      ticks(4);
      chk("R2", dut_out(), 5'b00010);
      reg_buf_pd = 1'b0;
      ticks(3);
      chk("R1", dut_out(), 5'b01100);
      reg_buf_pd = 1'b1; reg_core_sb = 1'b0;
      ticks(3);
      chk("R1", dut_out(), 5'b11010);
      reg_buf_pd = 1'b0;
      wake("R7", 2 + DD);
      pins(2'b11);
      ticks(4);
      chk("R2", dut_out(), 5'b11101);
      // back to pins, registers now ignored
      pins(2'b00);
      src_is_reg = 1'b0;
      reg_buf_pd = 1'b1; reg_core_sb = 1'b1;
      ticks(4);
      chk("R2", dut_out(), 5'b11101);

      // R9: command change during a running count restarts it
      cur_req = "R9";
      pins(2'b01);
      ticks(4);
      pins(2'b00);
      ticks(2 + DS / 2);
      chk("R9", dut_out(), 5'b11100);
      pins(2'b10);
      ticks(3);
      pins(2'b00);
      wake("R9", 2 + DD);

      // R8: lost sample clock
      cur_req = "R8";
      mid_window();
      smp_half = 0;
      ticks(4 * WIN);
      chk("R8", dut_out(), 5'b01100);
      mid_window();
      smp_half = 20;
      ticks(4 * WIN);
      chk("R8", dut_out(), 5'b01100);
      // commanded standby stays standby with clock still lost
      pins(2'b01);
      ticks(3);
      chk("R8", dut_out(), 5'b01100);
      pins(2'b10);
      ticks(3);
      chk("R8", dut_out(), 5'b11010);
      pins(2'b00);
      ticks(3);
      chk("R8", dut_out(), 5'b01100);
      mid_window();
      smp_half = 2;
      ticks(3 * WIN + DS + 4);
      chk("R8", dut_out(), 5'b11101);
      ticks(20);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule